// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned words of `WIDTH` bits (default 16) over several clock cycles. It gives a double-width product split across two result registers. `hi` holds the upper half and `lo` holds the lower half. The multiplicand sits in its own holding register. The multiplier word is not kept in a separate register: it is loaded into `lo`. Each step consumes its least significant bit while the newly settled product bits shift into the top of `lo`.

A single-cycle `start` while the unit is idle captures both operands and clears `hi`. Exactly `WIDTH` step cycles follow. In each step, the multiplicand is added to `hi` with a carry-out bit when the current bit of `lo` is set. The carry, `hi` and `lo` then move right by one place as one combined register. `done` pulses for one cycle when the last step finishes. The result then stays put until the next accepted `start`.

Top module: `shiftadd_mul`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `hi` and `lo` are all zero.
- R2: A `start` sampled high while `busy` is low is accepted. On the next cycle `busy` is 1, `hi` is 0 and `lo` equals the `mplier` value sampled with `start`. A `start` in the cycle where `done` is high is accepted too.
- R3: After k steps (0 ≤ k ≤ WIDTH), the concatenation {hi, lo} equals (mcand × (mplier mod 2^k)) × 2^(WIDTH−k) + (mplier >> k).
- R4: `done` is high for exactly one cycle. That cycle is WIDTH+1 cycles after the accepting edge. `busy` is low in that cycle and was high in each of the WIDTH cycles before it.
- R5: When `done` is high, {hi, lo} is the full unsigned product of the accepted operands. This holds for zero, one and all-ones operands.
- R6: While `busy` is low and no `start` is accepted, `hi` and `lo` do not change.
- R7: A `start` that arrives while `busy` is high has no effect. Both the timing and the product of the running multiply are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiply |
| mcand | input | WIDTH | Multiplicand, sampled on an accepted start |
| mplier | input | WIDTH | Multiplier, sampled on an accepted start |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| hi | output | WIDTH | Upper half of the product register |
| lo | output | WIDTH | Lower half of the product register |

## Verification
The product register is visible at the ports in every cycle. A wrong add decision, a lost carry or a misrouted shift bit shows up as a mismatch against the step formula of R3 in the very cycle after it happens, well before `done`. A step counter that is off by one moves the `done` pulse, which R4 catches at the edge concerned. The final product then also disagrees. A `start` that leaks in during a run corrupts `lo` on the following cycle.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } mul_state_e;

    typedef struct packed {
        logic load;
        logic step;
    } mul_cmd_t;

    function automatic int cnt_bits(input int w);
        return (w > 1) ? $clog2(w) : 1;
    endfunction

endpackage

// File: rtl/shiftadd_mul_ctrl.sv
module shiftadd_mul_ctrl
    import shiftadd_mul_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output mul_cmd_t cmd,
    output logic     busy,
    output logic     done
);
    localparam int CW = cnt_bits(WIDTH);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    mul_state_e    state;
    logic [CW-1:0] step_cnt;

    always_comb begin
        cmd.load = (state == ST_IDLE) && start;
        cmd.step = (state == ST_RUN);
        busy     = (state == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            step_cnt <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_RUN;
                        step_cnt <= '0;
                    end
                end
                default: begin
                    if (step_cnt == LAST) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        step_cnt <= step_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // R4: the completion pulse lasts one cycle only
    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: no completion while steps remain
    p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7: a request during a run does not end or restart it early
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && start && step_cnt != LAST) |=> (busy && !done));

endmodule

// File: rtl/shiftadd_mul_adder.sv
module shiftadd_mul_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] addend,
    input  logic             en,
    output logic [WIDTH:0]   sum
);
    always_comb begin
        sum = {1'b0, acc} + {1'b0, (en ? addend : {WIDTH{1'b0}})};
    end
endmodule

// File: rtl/shiftadd_mul_dp.sv
module shiftadd_mul_dp
    import shiftadd_mul_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  mul_cmd_t         cmd,
    input  logic [WIDTH-1:0] mcand,
    input  logic [WIDTH-1:0] mplier,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo
);
    logic [WIDTH-1:0] md;
    logic [WIDTH:0]   sum;

    shiftadd_mul_adder #(.WIDTH(WIDTH)) u_add (
        .acc    (hi),
        .addend (md),
        .en     (lo[0]),
        .sum    (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            md <= '0;
            hi <= '0;
            lo <= '0;
        end else if (cmd.load) begin
            md <= mcand;
            hi <= '0;
            lo <= mplier;
        end else if (cmd.step) begin
            hi <= sum[WIDTH:1];
            lo <= {sum[0], lo[WIDTH-1:1]};
        end
    end

    // R2: operands are captured on an accepted request
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (hi == '0) && (lo == $past(mplier)));

    // R6: product register holds when neither loading nor stepping
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!cmd.load && !cmd.step) |=> ($stable(hi) && $stable(lo)));

endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul
    import shiftadd_mul_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] mcand,
    input  logic [WIDTH-1:0] mplier,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo
);
    mul_cmd_t cmd;

    shiftadd_mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .cmd   (cmd),
        .busy  (busy),
        .done  (done)
    );

    shiftadd_mul_dp #(.WIDTH(WIDTH)) u_dp (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .mcand  (mcand),
        .mplier (mplier),
        .hi     (hi),
        .lo     (lo)
    );

endmodule

// File: tb/test_shiftadd_mul.sv
module test_shiftadd_mul;
    localparam int W = 16;
    localparam int WATCHDOG_CYC = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] mcand = '0;
    logic [W-1:0] mplier = '0;
    logic         busy, done;
    logic [W-1:0] hi, lo;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    shiftadd_mul #(.WIDTH(W)) i_shiftadd_mul (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .hi(hi), .lo(lo)
    );

    // behavioural reference model, advanced on every rising edge
    logic           m_busy = 1'b0;
    logic           m_done = 1'b0;
    logic [2*W-1:0] m_reg  = '0;
    logic [W-1:0]   m_a = '0, m_b = '0;
    int             m_k = 0;
    logic           model_ok = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 1'b0; m_done = 1'b0; m_reg = '0; m_k = 0;
            model_ok = 1'b1;
        end else begin
            m_done = 1'b0;
            if (!m_busy && start) begin
                m_a = mcand; m_b = mplier; m_k = 0; m_busy = 1'b1;
                m_reg = {{W{1'b0}}, mplier};
            end else if (m_busy) begin
                logic [W-1:0]   blow;
                logic [2*W-1:0] part;
                m_k  = m_k + 1;
                blow = m_b & ((W'(1) << m_k) - W'(1));
                part = {{W{1'b0}}, m_a} * {{W{1'b0}}, blow};
                m_reg = (part << (W - m_k)) | {{W{1'b0}}, (m_b >> m_k)};
                if (m_k == W) begin
                    m_busy = 1'b0;
                    m_done = 1'b1;
                end
            end
        end
    end

    task automatic check(input logic ok, input string tag,
                         input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (model_ok && !rst) begin
            check(busy == m_busy, "R2/R4 busy", {{(2*W-1){1'b0}}, busy}, {{(2*W-1){1'b0}}, m_busy});
            check(done == m_done, "R4 done", {{(2*W-1){1'b0}}, done}, {{(2*W-1){1'b0}}, m_done});
            check({hi, lo} == m_reg, m_busy ? "R3 step value" : "R6 held value", {hi, lo}, m_reg);
        end
    end

    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input bit poke);
        logic [2*W-1:0] prod;
        int cyc;
        prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        start = 1'b1; mcand = a; mplier = b;
        @(negedge clk);
        start = 1'b0; mcand = ~a; mplier = ~b;
        check(busy && hi == '0 && lo == b, "R2 load", {hi, lo}, {{W{1'b0}}, b});
        cyc = 1;
        while (!done) begin
            if (poke && cyc == 3) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(cyc == W + 1, "R4 latency", 2*W'(cyc), 2*W'(W + 1));
        check({hi, lo} == prod, poke ? "R7 product after ignored start" : "R5 product",
              {hi, lo}, prod);
    endtask

    task automatic main;
        repeat (3) @(negedge clk);
        check(!busy && !done && hi == '0 && lo == '0, "R1 reset", {hi, lo}, '0);
        rst = 1'b0;
        // R6: idle cycles with garbage operands and no start
        mcand = 16'h1234; mplier = 16'h5678;
        repeat (3) @(negedge clk);
        check({hi, lo} == '0, "R6 idle hold", {hi, lo}, '0);
        run('0, '0, 1'b0);
        run('1, '1, 1'b0);
        run(16'd1, 16'hBEEF, 1'b0);
        run(16'hCAFE, 16'd1, 1'b0);
        run('1, 16'd1, 1'b0);
        run(16'h8000, 16'h8000, 1'b0);
        run(16'h00FF, 16'hFF00, 1'b1);   // R7
        run(16'hA5A5, 16'h5A5A, 1'b0);   // R2: accepted in the done cycle
        repeat (4) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            run(W'($urandom), W'($urandom), (i % 4) == 1);
            repeat (i % 3) @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        fork
            main();
            begin
                repeat (WATCHDOG_CYC) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule